// File: doc/BRIEF.md
# Fractional Baud Tick Generator with Oversampling Select

This block turns a reference clock into the sample-rate and bit-rate strobes that the transmit and receive shifters of a UART consume. The reference clock first passes a prescaler that divides by 1 or by 4. A 16-bit integer divisor then sets the sample-tick period. A 4-bit fractional part adds N/16 of a prescaled clock to that period on average. A two-bit mode picks whether one bit lasts 16, 8 or 4 sample ticks.

The block holds two generators, one for the transmit direction and one for the receive direction. Both are loaded through a single set of write strobes that share one data byte. A steering input decides which generators take a write, so the two directions can run at different rates or at the same rate. Written values are staged and move into the running counter only when the current period ends.

Top module: `uart_tick_gen`

## Requirements
- R1: After reset all four tick outputs are low and stay low until a nonzero divisor is written, because both divisor bytes reset to zero.
- R2: Steering input `steer_i` gates which generators take a write: 2'b01 loads the transmit generator only, 2'b10 loads the receive generator only, and 2'b00 or 2'b11 loads both. A generator that takes no write keeps its rate.
- R3: With `presc_sel_i`=0 every reference clock is a prescaled clock. With `presc_sel_i`=1 only every fourth reference clock is one. The count is a free-running modulo-4 counter that starts at reset, so a divisor of 3 gives sample ticks 12 clocks apart.
- R4: With a fractional part of zero, sample ticks come exactly D prescaled clocks apart, where D is the divisor.
- R5: A divisor of zero stops the sample and bit ticks of that generator once its current period has ended.
- R6: The fractional part N is bits 3:0 of the fractional byte. A 4-bit phase accumulator adds N once per period, and a period is one prescaled clock longer whenever the sum reaches 16. Any 16 consecutive periods therefore span 16*D+N prescaled clocks.
- R7: Bits 5:4 of the fractional byte select the oversampling rate. 2'b00 gives a bit tick every 16 sample ticks, 2'b01 every 8, and 2'b10 or 2'b11 every 4. A bit tick is always raised in the same cycle as a sample tick.
- R8: Changes to the divisor, the fractional part and the mode take effect at the next terminal count. The period that is running when the write happens completes at its old length.
- R9: The divisor is {high byte, low byte}, written through `wr_hi_i` and `wr_lo_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| steer_i | input | 2 | Write steering: 01 transmit, 10 receive, 00/11 both |
| presc_sel_i | input | 1 | 0: prescale by 1, 1: prescale by 4 |
| wr_lo_i | input | 1 | Write strobe, divisor low byte |
| wr_hi_i | input | 1 | Write strobe, divisor high byte |
| wr_frac_i | input | 1 | Write strobe, fractional/mode byte |
| wr_data_i | input | 8 | Write data shared by the three strobes |
| tx_sample_o | output | 1 | Transmit sample tick, one clock wide |
| tx_bit_o | output | 1 | Transmit bit tick, one clock wide |
| rx_sample_o | output | 1 | Receive sample tick, one clock wide |
| rx_bit_o | output | 1 | Receive bit tick, one clock wide |

## Verification
The bench first targets a write made in the middle of a period. A design that loads the new divisor at once would cut the running period short, giving a gap of 2 where 10 is expected. The bench then sums 16 consecutive periods with fractional parts 5 and 15. A design that drops or mis-spreads the carry would be off from 16*D+N. It also checks that a write steered to one direction leaves the other direction's rate unchanged, where a leaking steering decode would shift it. Finally it checks that a zero divisor silences the ticks, where a counter that wraps would instead tick every 65536 clocks.

// File: rtl/uart_tick_pkg.sv
package uart_tick_pkg;
  typedef enum logic [1:0] {
    STEER_BOTH  = 2'b00,
    STEER_TX    = 2'b01,
    STEER_RX    = 2'b10,
    STEER_BOTH2 = 2'b11
  } steer_e;

  // sample count of last tick in a bit, per oversampling mode
  function automatic logic [3:0] os_last(input logic [1:0] mode);
    case (mode)
      2'b00:   return 4'd15;
      2'b01:   return 4'd7;
      default: return 4'd3;
    endcase
  endfunction
endpackage

// File: rtl/uart_tick_presc.sv
module uart_tick_presc #(
  parameter int PRE_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic en_o
);
  localparam int PW = $clog2(PRE_DIV);
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + PW'(1);
  end

  assign en_o = sel_i ? (cnt_q == LAST) : 1'b1;

  AST_PRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && en_o) |=> (!sel_i || !en_o)); // R3
endmodule

// File: rtl/uart_tick_div.sv
module uart_tick_div
  import uart_tick_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pre_en_i,
  input  logic       wr_lo_i,
  input  logic       wr_hi_i,
  input  logic       wr_frac_i,
  input  logic [7:0] wr_data_i,
  output logic       sample_o,
  output logic       bit_o
);
  localparam int HI_W = DIV_W - 8;

  logic [7:0]        lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [FRAC_W-1:0] frac_q;
  logic [1:0]        mode_q;
  logic [DIV_W-1:0]  act_div_q, cnt_q, stg_div;
  logic [1:0]        act_mode_q;
  logic [FRAC_W-1:0] acc_q;
  logic [3:0]        sc_q;
  logic [FRAC_W:0]   sum;
  logic              tc, hit, bit_hit;

  // staged register set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      frac_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_lo_i) lo_q <= wr_data_i;
      if (wr_hi_i) hi_q <= wr_data_i[HI_W-1:0];
      if (wr_frac_i) begin
        frac_q <= wr_data_i[FRAC_W-1:0];
        mode_q <= wr_data_i[5:4];
      end
    end
  end

  assign stg_div = {hi_q, lo_q};
  assign tc      = pre_en_i && (cnt_q == '0);
  assign hit     = tc && (act_div_q != '0);
  assign bit_hit = hit && (sc_q >= os_last(act_mode_q));
  assign sum     = {1'b0, acc_q} + {1'b0, frac_q};

  // period counter; staged values move in only at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_div_q  <= '0;
      act_mode_q <= '0;
      acc_q      <= '0;
      cnt_q      <= '0;
    end else if (tc) begin
      act_div_q  <= stg_div;
      act_mode_q <= mode_q;
      acc_q      <= sum[FRAC_W-1:0];
      cnt_q      <= (stg_div == '0) ? '0
                  : stg_div - DIV_W'(1) + DIV_W'(sum[FRAC_W]);
    end else if (pre_en_i) begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q     <= '0;
      sample_o <= 1'b0;
      bit_o    <= 1'b0;
    end else begin
      sample_o <= hit;
      bit_o    <= bit_hit;
      if (hit) sc_q <= bit_hit ? '0 : sc_q + 4'd1;
    end
  end

  AST_STOP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_div_q == '0) |=> !sample_o); // R5
  AST_BIT_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> sample_o); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_div_q); // R4
  AST_HOLD_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc |=> ($stable(act_div_q) && $stable(act_mode_q))); // R8
endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen
  import uart_tick_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int FRAC_W  = 4,
  parameter int PRE_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] steer_i,
  input  logic       presc_sel_i,
  input  logic       wr_lo_i,
  input  logic       wr_hi_i,
  input  logic       wr_frac_i,
  input  logic [7:0] wr_data_i,
  output logic       tx_sample_o,
  output logic       tx_bit_o,
  output logic       rx_sample_o,
  output logic       rx_bit_o
);
  localparam int NGEN = 2; // 0: transmit, 1: receive

  logic            pre_en;
  logic [NGEN-1:0] take, samp, bitt;

  uart_tick_presc #(.PRE_DIV(PRE_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (presc_sel_i),
    .en_o  (pre_en)
  );

  assign take[0] = (steer_e'(steer_i) != STEER_RX);
  assign take[1] = (steer_e'(steer_i) != STEER_TX);

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    uart_tick_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pre_en_i (pre_en),
      .wr_lo_i  (wr_lo_i && take[g]),
      .wr_hi_i  (wr_hi_i && take[g]),
      .wr_frac_i(wr_frac_i && take[g]),
      .wr_data_i(wr_data_i),
      .sample_o (samp[g]),
      .bit_o    (bitt[g])
    );
  end

  assign tx_sample_o = samp[0];
  assign tx_bit_o    = bitt[0];
  assign rx_sample_o = samp[1];
  assign rx_bit_o    = bitt[1];
endmodule

// File: tb/uart_tick_gen_tb_top.sv
module uart_tick_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] steer_i = 2'b00;
  logic presc_sel_i = 1'b0, wr_lo_i = 1'b0, wr_hi_i = 1'b0, wr_frac_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic tx_sample_o, tx_bit_o, rx_sample_o, rx_bit_o;

  int total = 0, bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_tick_gen dut_i (.*);

  // ---------------- behavioural reference model ----------------
  int m_lo[2], m_hi[2], m_fd[2], m_act[2], m_amode[2], m_acc[2], m_cnt[2], m_sc[2];
  bit m_s[2], m_b[2];
  int m_pc;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pc = 0;
      for (int g = 0; g < 2; g++) begin
        m_lo[g] = 0; m_hi[g] = 0; m_fd[g] = 0; m_act[g] = 0; m_amode[g] = 0;
        m_acc[g] = 0; m_cnt[g] = 0; m_sc[g] = 0; m_s[g] = 0; m_b[g] = 0;
      end
    end else begin
      bit pre;
      pre = presc_sel_i ? (m_pc == 3) : 1'b1;
      m_pc = (m_pc + 1) % 4;
      for (int g = 0; g < 2; g++) begin
        bit tc, takes;
        int last, nd, sm;
        tc = pre && (m_cnt[g] == 0);
        last = (m_amode[g] == 0) ? 15 : (m_amode[g] == 1) ? 7 : 3;
        m_s[g] = tc && (m_act[g] != 0);
        m_b[g] = m_s[g] && (m_sc[g] >= last);
        if (m_s[g]) m_sc[g] = m_b[g] ? 0 : m_sc[g] + 1;
        if (tc) begin
          nd = m_hi[g] * 256 + m_lo[g];
          sm = m_acc[g] + (m_fd[g] % 16);
          m_act[g] = nd;
          m_amode[g] = (m_fd[g] / 16) % 4;
          m_acc[g] = sm % 16;
          m_cnt[g] = (nd == 0) ? 0 : nd - 1 + (sm >= 16 ? 1 : 0);
        end else if (pre) m_cnt[g] = m_cnt[g] - 1;
        takes = (g == 0) ? (steer_i != 2'b10) : (steer_i != 2'b01);
        if (takes) begin
          if (wr_lo_i) m_lo[g] = wr_data_i;
          if (wr_hi_i) m_hi[g] = wr_data_i;
          if (wr_frac_i) m_fd[g] = wr_data_i & 8'h3F;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      total++;
      if ({tx_sample_o, tx_bit_o, rx_sample_o, rx_bit_o} !==
          {m_s[0], m_b[0], m_s[1], m_b[1]}) begin
        bad++;
        $display("FAIL %s model compare: actual=%b expected=%b", cur_req,
                 {tx_sample_o, tx_bit_o, rx_sample_o, rx_bit_o},
                 {m_s[0], m_b[0], m_s[1], m_b[1]});
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic tk(input int g);
    return (g == 0) ? tx_sample_o : rx_sample_o;
  endfunction

  function automatic logic bk(input int g);
    return (g == 0) ? tx_bit_o : rx_bit_o;
  endfunction

  task automatic wr(input int which, input logic [7:0] d);
    wr_data_i = d;
    wr_lo_i = (which == 0); wr_hi_i = (which == 1); wr_frac_i = (which == 2);
    @(negedge clk_i);
    wr_lo_i = 0; wr_hi_i = 0; wr_frac_i = 0;
  endtask

  task automatic gap(input int g, output int n);
    while (!tk(g)) @(negedge clk_i);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tk(g));
  endtask

  task automatic bit_span(input int g, output int n);
    while (!bk(g)) @(negedge clk_i);
    n = 0;
    do begin @(negedge clk_i); if (tk(g)) n++; end while (!bk(g));
  endtask

  task automatic count_ticks(input int g, input int cycles, output int n);
    n = 0;
    repeat (cycles) begin @(negedge clk_i); if (tk(g)) n++; end
  endtask

  task automatic sum16(input int g, output int s);
    int n;
    s = 0;
    for (int i = 0; i < 16; i++) begin gap(g, n); s += n; end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int n, s;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: silent after reset
    cur_req = "R1";
    count_ticks(0, 20, n); chk("R1 tx ticks after reset", n, 0);
    count_ticks(1, 20, n); chk("R1 rx ticks after reset", n, 0);
    chk("R1 bit outputs low", int'(tx_bit_o | rx_bit_o), 0);

    // R2/R4: transmit only, divisor 3
    cur_req = "R4";
    steer_i = 2'b01;
    wr(0, 8'd3); wr(1, 8'd0); wr(2, 8'h00);
    repeat (10) @(negedge clk_i);
    gap(0, n); chk("R4 tx gap div3", n, 3);
    cur_req = "R2";
    count_ticks(1, 50, n); chk("R2 rx untouched by tx write", n, 0);

    // R2/R7: receive only, divisor 5, 8X
    steer_i = 2'b10;
    wr(0, 8'd5); wr(2, 8'h10);
    repeat (20) @(negedge clk_i);
    gap(1, n); chk("R2 rx gap div5", n, 5);
    gap(0, n); chk("R2 tx keeps div3", n, 3);
    cur_req = "R7";
    repeat (200) @(negedge clk_i);
    bit_span(1, n); chk("R7 rx 8X span", n, 8);
    bit_span(0, n); chk("R7 tx 16X span", n, 16);

    // both, divisor 2, 4X
    cur_req = "R2";
    steer_i = 2'b00;
    wr(0, 8'd2); wr(2, 8'h20);
    repeat (50) @(negedge clk_i);
    gap(0, n); chk("R2 both tx gap", n, 2);
    gap(1, n); chk("R2 both rx gap", n, 2);
    cur_req = "R7";
    repeat (100) @(negedge clk_i);
    bit_span(0, n); chk("R7 tx 4X span", n, 4);
    steer_i = 2'b11;
    wr(2, 8'h30);
    repeat (100) @(negedge clk_i);
    bit_span(1, n); chk("R7 rx mode 11 span", n, 4);

    // R9: divisor from high and low bytes
    cur_req = "R9";
    wr(1, 8'd1);
    repeat (600) @(negedge clk_i);
    gap(0, n); chk("R9 divisor 0x0102", n, 258);
    wr(1, 8'd0);

    // R6: fractional spread
    cur_req = "R6";
    wr(0, 8'd4); wr(2, 8'h05);
    repeat (600) @(negedge clk_i);
    sum16(0, s); chk("R6 16 periods frac5", s, 69);
    wr(2, 8'h0F);
    repeat (100) @(negedge clk_i);
    sum16(1, s); chk("R6 16 periods frac15", s, 79);

    // R3: prescaler by 4
    cur_req = "R3";
    wr(2, 8'h00); wr(0, 8'd3);
    presc_sel_i = 1'b1;
    repeat (60) @(negedge clk_i);
    gap(0, n); chk("R3 prescale4 div3", n, 12);
    presc_sel_i = 1'b0;

    // R8: write mid-period
    cur_req = "R8";
    wr(0, 8'd10);
    repeat (40) @(negedge clk_i);
    while (!tk(0)) @(negedge clk_i);
    n = 0;
    repeat (3) begin @(negedge clk_i); n++; end
    wr(0, 8'd2); n++;
    while (!tk(0)) begin @(negedge clk_i); n++; end
    chk("R8 running period kept", n, 10);
    gap(0, n); chk("R8 new period applied", n, 2);

    // R5: zero divisor stops ticks
    cur_req = "R5";
    wr(0, 8'd0);
    repeat (30) @(negedge clk_i);
    count_ticks(0, 100, n); chk("R5 tx stopped", n, 0);
    count_ticks(1, 100, n); chk("R5 rx stopped", n, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog (%s): actual=hung expected=finished", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule